// File: doc/BRIEF.md
# Multi-Space Memory Address Mapper

This block sits between the CPU and DMA master ports of a small 8-bit microcontroller and the physical memories. It takes a logical space and an address. The logical space is one of external data, code, internal data or register space. The block returns which physical memory is addressed and the byte offset inside it. The memories are on-chip flash, an 8 KB SRAM and a 128-entry peripheral register file. The decode is purely combinational, so the memories see the select and offset in the same cycle as the address.

One small control register sets how code space is decoded. A unify bit places SRAM and the register file into code space, with the same layout as in external data space. A two-bit bank field picks which 32 KB flash bank appears in the upper half of code space. The flash size is a build parameter with two settings: 32 KB and 128 KB. Some register-file entries are backed by storage inside the CPU core. A parameter mask lists these entries, and they are hidden from the memory-mapped alias.

Every decode returns a definite target. An address that reaches no memory raises an unmapped flag. A retention flag marks SRAM bytes that are kept through the deepest low-power state.

Top module: `mem_space_mapper`

## Requirements
- R1: After a synchronous reset the control register reads 0, meaning split code mapping and bank 0.
- R2: A write on `ctl_we` updates the control register at the next rising clock edge, and the read port shows it combinationally. Bit 2 is the unify enable and bits 1:0 are the flash bank.
- R3: In external data space, addresses 0xE000–0xFFFF select SRAM at offset address−0xE000, for both flash sizes.
- R4: In external data space, addresses 0xDF80–0xDFFF select register-file entry address−0xDF80. Entries flagged in `CORE_MASK` are reported unmapped instead.
- R5: With 128 KB flash, external data addresses 0x0000–0xDEFF select flash at offset equal to the address, and 0xDF00–0xDF7F is unmapped.
- R6: With 32 KB flash, addresses 0x8000–0xDEFF are unmapped in external data space and in unified code space. The whole of code 0x8000–0xFFFF is unmapped in split mode.
- R7: Code addresses 0x0000–0x7FFF select flash at offset equal to the address, whatever the control register holds.
- R8: In split mode with 128 KB flash, code addresses 0x8000–0xFFFF select flash offset {bank, address[14:0]}. Split-mode code never selects SRAM or the register file.
- R9: In unified mode, code addresses 0x8000–0xDEFF select banked flash {bank, address[14:0]}. Code 0xDF00–0xFFFF decodes as in external data space, including the hidden core entries.
- R10: Internal data space selects SRAM at offset 0x1F00 + address[7:0]. Address bits 15:8 are ignored.
- R11: In register space, address[7:0] in 0x80–0xFF selects register-file entry address[6:0], and lower values are unmapped. Core entries are reachable here.
- R12: `retain` is 1 exactly when the target is SRAM and the offset is 0x1000 or above.
- R13: `unmapped` is 1 exactly when the target code is 0 (none), and then the offset is 0. Target codes are 0 none, 1 flash, 2 SRAM, 3 register file. Space codes are 0 external data, 1 code, 2 internal data, 3 register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data {unify, bank[1:0]} |
| ctl_rdata | output | 3 | Control register value |
| acc_space | input | 2 | Logical space of the access |
| acc_addr | input | 16 | Logical address |
| tgt_sel | output | 2 | Target memory select |
| phys_off | output | 17 | Byte offset in the target memory |
| unmapped | output | 1 | Access reaches no memory |
| retain | output | 1 | Byte is kept in the deepest low-power state |

## Verification
The embedded properties check these rules on every clock:
- the retention flag agrees with the SRAM offset;
- split-mode code never reaches SRAM or registers;
- the top SRAM window of external data space always lands on SRAM with the right offset;
- banked code offsets follow the bank field;
- control writes land one edge later.

Other behaviour shows only through the bench's scenarios, which compare both flash sizes against an independent model:
- the exact boundaries 0xDEFF/0xDF00/0xDF7F/0xDF80;
- hiding of the core entries;
- the split/unified switch that follows a register write;
- the 32 KB holes.

// File: rtl/msm_pkg.sv
package msm_pkg;

    localparam int OFF_W       = 17;
    localparam int SRAM_AW     = 13;
    localparam int REG_AW      = 7;
    localparam int BANK_W      = 2;
    localparam logic [15:0] SRAM_BASE  = 16'hE000;
    localparam logic [15:0] REG_BASE   = 16'hDF80;
    localparam logic [15:0] FLASH_LAST = 16'hDEFF;
    localparam logic [7:0]  IDATA_PAGE = 8'h1F;

    typedef enum logic [1:0] {
        SPC_EXT  = 2'd0,
        SPC_CODE = 2'd1,
        SPC_INT  = 2'd2,
        SPC_REG  = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_SRAM  = 2'd2,
        TGT_REGS  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic              unify;
        logic [BANK_W-1:0] bank;
    } memctl_t;

    typedef struct packed {
        tgt_e             tgt;
        logic [OFF_W-1:0] off;
        logic             retain;
    } map_res_t;

    function automatic map_res_t res_none();
        map_res_t r;
        r.tgt    = TGT_NONE;
        r.off    = '0;
        r.retain = 1'b0;
        return r;
    endfunction

    function automatic map_res_t res_flash(input logic [OFF_W-1:0] o);
        map_res_t r;
        r.tgt    = TGT_FLASH;
        r.off    = o;
        r.retain = 1'b0;
        return r;
    endfunction

    function automatic map_res_t res_sram(input logic [SRAM_AW-1:0] o);
        map_res_t r;
        r.tgt    = TGT_SRAM;
        r.off    = {{(OFF_W-SRAM_AW){1'b0}}, o};
        r.retain = o[SRAM_AW-1];
        return r;
    endfunction

    function automatic map_res_t res_regs(input logic [REG_AW-1:0] i);
        map_res_t r;
        r.tgt    = TGT_REGS;
        r.off    = {{(OFF_W-REG_AW){1'b0}}, i};
        r.retain = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/msm_ctl_reg.sv
module msm_ctl_reg
    import msm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  memctl_t wdata,
    output memctl_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata;
    end

    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));

    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/msm_unified_dec.sv
module msm_unified_dec
    import msm_pkg::*;
#(
    parameter bit           BIG_FLASH = 1'b1,
    parameter bit           CODE_VIEW = 1'b0,
    parameter logic [127:0] CORE_MASK = '0
)(
    input  logic [15:0]       addr,
    input  logic [BANK_W-1:0] bank,
    output map_res_t          res
);

    logic [OFF_W-1:0] upper_flash;

    generate
        if (CODE_VIEW) begin : g_banked
            assign upper_flash = {bank, addr[14:0]};
        end else begin : g_linear
            assign upper_flash = {{(OFF_W-16){1'b0}}, addr};
        end
    endgenerate

    always_comb begin
        if (addr >= SRAM_BASE)
            res = res_sram(addr[SRAM_AW-1:0]);
        else if (addr >= REG_BASE)
            res = CORE_MASK[addr[REG_AW-1:0]] ? res_none() : res_regs(addr[REG_AW-1:0]);
        else if (addr > FLASH_LAST)
            res = res_none();
        else if (!addr[15])
            res = res_flash({{(OFF_W-16){1'b0}}, addr});
        else if (!BIG_FLASH)
            res = res_none();
        else
            res = res_flash(upper_flash);
    end

endmodule

// File: rtl/msm_code_dec.sv
module msm_code_dec
    import msm_pkg::*;
#(
    parameter bit BIG_FLASH = 1'b1
)(
    input  logic [15:0] addr,
    input  memctl_t     ctl,
    input  map_res_t    uni_res,
    output map_res_t    res
);

    map_res_t split_res;

    always_comb begin
        if (!addr[15])
            split_res = res_flash({{(OFF_W-16){1'b0}}, addr});
        else if (BIG_FLASH)
            split_res = res_flash({ctl.bank, addr[14:0]});
        else
            split_res = res_none();
    end

    assign res = ctl.unify ? uni_res : split_res;

endmodule

// File: rtl/mem_space_mapper.sv
module mem_space_mapper
    import msm_pkg::*;
#(
    parameter int           FLASH_KB  = 128,
    parameter logic [127:0] CORE_MASK = 128'h0001_0001_0001_0000_0000_0000_0000_000E
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [2:0]  ctl_wdata,
    output logic [2:0]  ctl_rdata,
    input  logic [1:0]  acc_space,
    input  logic [15:0] acc_addr,
    output logic [1:0]  tgt_sel,
    output logic [16:0] phys_off,
    output logic        unmapped,
    output logic        retain
);

    localparam bit BIG_FLASH = (FLASH_KB > 32);

    memctl_t  ctl_q;
    map_res_t ext_res, cview_res, code_res, sel_res;

    msm_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (memctl_t'(ctl_wdata)),
        .q     (ctl_q)
    );

    msm_unified_dec #(.BIG_FLASH(BIG_FLASH), .CODE_VIEW(1'b0), .CORE_MASK(CORE_MASK)) u_ext (
        .addr (acc_addr),
        .bank (ctl_q.bank),
        .res  (ext_res)
    );

    msm_unified_dec #(.BIG_FLASH(BIG_FLASH), .CODE_VIEW(1'b1), .CORE_MASK(CORE_MASK)) u_cview (
        .addr (acc_addr),
        .bank (ctl_q.bank),
        .res  (cview_res)
    );

    msm_code_dec #(.BIG_FLASH(BIG_FLASH)) u_code (
        .addr    (acc_addr),
        .ctl     (ctl_q),
        .uni_res (cview_res),
        .res     (code_res)
    );

    always_comb begin
        case (space_e'(acc_space))
            SPC_EXT:  sel_res = ext_res;
            SPC_CODE: sel_res = code_res;
            SPC_INT:  sel_res = res_sram({IDATA_PAGE[SRAM_AW-9:0], acc_addr[7:0]});
            default:  sel_res = acc_addr[7] ? res_regs(acc_addr[REG_AW-1:0]) : res_none();
        endcase
    end

    assign ctl_rdata = ctl_q;
    assign tgt_sel   = sel_res.tgt;
    assign phys_off  = sel_res.off;
    assign retain    = sel_res.retain;
    assign unmapped  = (sel_res.tgt == TGT_NONE);

    assert_retain_sram_R12: assert property (@(posedge clk) disable iff (rst)
        retain |-> (tgt_sel == TGT_SRAM && phys_off >= 17'h01000));

    assert_split_no_ram_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_space == SPC_CODE && !ctl_rdata[2]) |-> (tgt_sel != TGT_SRAM && tgt_sel != TGT_REGS));

    assert_ext_sram_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_space == SPC_EXT && acc_addr >= 16'hE000)
            |-> (tgt_sel == TGT_SRAM && phys_off == {4'd0, acc_addr[12:0]}));

    assert_bank_off_R9: assert property (@(posedge clk) disable iff (rst)
        (BIG_FLASH && acc_space == SPC_CODE && acc_addr[15] && acc_addr < 16'hDF00)
            |-> (tgt_sel == TGT_FLASH && phys_off == {ctl_rdata[1:0], acc_addr[14:0]}));

    assert_none_zero_R13: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (phys_off == '0 && !retain));

    assert_idata_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_space == SPC_INT) |-> (tgt_sel == TGT_SRAM && phys_off[12:8] == 5'h1F));

endmodule

// File: tb/mem_space_mapper_tb_top.sv
`timescale 1ns/1ps
module mem_space_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [1:0]  acc_space = '0;
    logic [15:0] acc_addr = '0;
    logic [2:0]  rd_b, rd_s;
    logic [1:0]  tg_b, tg_s;
    logic [16:0] of_b, of_s;
    logic        um_b, um_s, rt_b, rt_s;

    int checks = 0;
    int errors = 0;
    logic [2:0] ctl_m = '0;

    always #2.5 clk = ~clk;

    mem_space_mapper #(.FLASH_KB(128)) dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(rd_b),
        .acc_space(acc_space), .acc_addr(acc_addr),
        .tgt_sel(tg_b), .phys_off(of_b), .unmapped(um_b), .retain(rt_b));

    mem_space_mapper #(.FLASH_KB(32)) dut32_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(rd_s),
        .acc_space(acc_space), .acc_addr(acc_addr),
        .tgt_sel(tg_s), .phys_off(of_s), .unmapped(um_s), .retain(rt_s));

    function automatic bit is_core(input logic [6:0] i);
        return (i == 7'd1 || i == 7'd2 || i == 7'd3 || i == 7'd80 || i == 7'd96 || i == 7'd112);
    endfunction

    function automatic void ref_map(input bit big, input logic [1:0] sp, input logic [15:0] a,
                                    input logic [2:0] c, output logic [1:0] t,
                                    output logic [16:0] o, output string tag);
        t = 2'd0; o = '0; tag = "R13";
        if (sp == 2'd2) begin
            t = 2'd2; o = 17'h01F00 + {9'd0, a[7:0]}; tag = "R10";
        end else if (sp == 2'd3) begin
            tag = "R11";
            if (a[7]) begin t = 2'd3; o = {10'd0, a[6:0]}; end
        end else if (sp == 2'd1 && a < 16'h8000) begin
            t = 2'd1; o = {1'b0, a}; tag = "R7";
        end else if (sp == 2'd1 && !c[2]) begin
            tag = big ? "R8" : "R6";
            if (big) begin t = 2'd1; o = {c[1:0], a[14:0]}; end
        end else begin
            if (a >= 16'hE000) begin
                t = 2'd2; o = {4'd0, a[12:0]}; tag = (sp == 2'd1) ? "R9" : "R3";
            end else if (a >= 16'hDF80) begin
                tag = (sp == 2'd1) ? "R9" : "R4";
                if (!is_core(a[6:0])) begin t = 2'd3; o = {10'd0, a[6:0]}; end
            end else if (a >= 16'hDF00) begin
                tag = (sp == 2'd1) ? "R9" : "R5";
            end else if (a < 16'h8000) begin
                t = 2'd1; o = {1'b0, a}; tag = "R5";
            end else if (!big) begin
                tag = "R6";
            end else begin
                t = 2'd1;
                o = (sp == 2'd1) ? {c[1:0], a[14:0]} : {1'b0, a};
                tag = (sp == 2'd1) ? "R9" : "R5";
            end
        end
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (space %0d addr %h ctl %b)",
                     tag, what, act, exp, acc_space, acc_addr, ctl_m);
        end
    endtask

    task automatic probe(input logic [1:0] sp, input logic [15:0] a);
        logic [1:0] t; logic [16:0] o; string tag;
        @(negedge clk);
        acc_space = sp; acc_addr = a;
        #1;
        ref_map(1'b1, sp, a, ctl_m, t, o, tag);
        chk(tag, "tgt128", int'(tg_b), int'(t));
        chk(tag, "off128", int'(of_b), int'(o));
        chk("R13", "unmapped128", int'(um_b), int'(t == 2'd0));
        chk("R12", "retain128", int'(rt_b), int'(t == 2'd2 && o >= 17'h01000));
        ref_map(1'b0, sp, a, ctl_m, t, o, tag);
        chk(tag, "tgt32", int'(tg_s), int'(t));
        chk(tag, "off32", int'(of_s), int'(o));
        chk("R13", "unmapped32", int'(um_s), int'(t == 2'd0));
        chk("R12", "retain32", int'(rt_s), int'(t == 2'd2 && o >= 17'h01000));
    endtask

    task automatic wr_ctl(input logic [2:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        #1;
        chk("R2", "ctl before edge", int'(rd_b), int'(ctl_m));
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_m = v;
        chk("R2", "ctl after edge", int'(rd_b), int'(v));
        chk("R2", "ctl after edge 32", int'(rd_s), int'(v));
    endtask

    task automatic corners();
        probe(2'd0, 16'h0000); probe(2'd0, 16'h7FFF); probe(2'd0, 16'h8000);
        probe(2'd0, 16'hDEFF); probe(2'd0, 16'hDF00); probe(2'd0, 16'hDF7F);
        probe(2'd0, 16'hDF80); probe(2'd0, 16'hDF81); probe(2'd0, 16'hDFD0);
        probe(2'd0, 16'hDFFF); probe(2'd0, 16'hE000); probe(2'd0, 16'hEFFF);
        probe(2'd0, 16'hF000); probe(2'd0, 16'hFFFF);
        probe(2'd1, 16'h0000); probe(2'd1, 16'h7FFF); probe(2'd1, 16'h8000);
        probe(2'd1, 16'hDEFF); probe(2'd1, 16'hDF00); probe(2'd1, 16'hDF84);
        probe(2'd1, 16'hDF83); probe(2'd1, 16'hE000); probe(2'd1, 16'hFFFF);
        probe(2'd2, 16'h0000); probe(2'd2, 16'hAB7F); probe(2'd2, 16'h00FF);
        probe(2'd3, 16'h007F); probe(2'd3, 16'h0080); probe(2'd3, 16'h12E0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        chk("R1", "ctl during reset", int'(rd_b), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ctl after reset", int'(rd_b), 0);
        chk("R1", "ctl after reset 32", int'(rd_s), 0);
        corners();
        for (int b = 0; b < 4; b++) begin
            wr_ctl({1'b0, 2'(b)});
            corners();
            wr_ctl({1'b1, 2'(b)});
            corners();
        end
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) wr_ctl(3'($urandom_range(0, 7)));
            case ($urandom_range(0, 3))
                0: probe(2'($urandom), 16'($urandom_range(16'hDF00, 16'hFFFF)));
                default: probe(2'($urandom), 16'($urandom));
            endcase
        end
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ctl_m = '0;
        chk("R1", "ctl after second reset", int'(rd_b), 0);
        probe(2'd1, 16'hE000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule